// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects a vector of peripheral interrupt request lines into a single status word and reduces that word to a three-bit priority level. A 68k-style processor samples the level. Every request line has an enable-inhibit bit in a companion mask word. When an inhibited line rises, the event is discarded. When an enabled line rises, its status bit is set. Whenever a line falls, its status bit clears.

Software reaches the block through a small register port with four word addresses:

| Address | Register |
|---------|----------|
| 0 | Status word |
| 1 | Mask word |
| 2 | Single-bit control port for one chosen status bit |
| 3 | Unused |

A write to the status or mask address replaces the whole word. Reads come from a separate read address, are combinational and have no side effects.

Status bits fall into three fixed priority groups, chosen by two parameter maps:
- Bits named in the level-6 map drive level 6.
- Bits named in the level-5 map drive level 5.
- Every other bit drives level 3.

The output level is the highest group that has a bit set, or 0 when the status word is clear. Vectoring, acknowledge cycles and the peripherals themselves are outside this block.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After synchronous reset the status word, the mask word and the priority level all read 0.
- R2: A rising edge on a request line whose mask bit is 0 sets that status bit on the clock edge that samples the rise.
- R3: A rising edge on a request line whose mask bit is 1 leaves that status bit unchanged.
- R4: A falling edge on a request line clears its status bit, whatever its mask bit holds.
- R5: A write to address 0 replaces every status bit with the written data.
- R6: A write to address 1 replaces the whole mask word with the written data.
- R7: A write to address 2 copies write-data bit 0 into status bit DIRECT_BIT (default 26) and leaves every other status bit as it was.
- R8: When a request-line event and a write to the status word (address 0 or 2) hit the same status bit in one cycle, the request-line event decides that bit. The other bits still take the written value.
- R9: The priority level is 6 if any status bit in the level-6 map (default bits 18 and 19) is set. Otherwise it is 5 if any bit in the level-5 map (default bit 17) is set. Otherwise it is 3 if any other status bit is set. Otherwise it is 0.
- R10: Reads have no side effects. Address 3 reads as 0, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive peripheral request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 status, 1 mask, 2 single-bit control, 3 unused) |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | DATA_W | Combinational read data |
| ipl_o | output | 3 | Priority level presented to the processor |

## Verification
The bench builds the block with the default parameters:
- NUM_SRC equals DATA_W at 32, so status bits 31, 26, 18 and 17 all exist and can be reached by the same written words.
- DIRECT_BIT stays at 26, so a request line on bit 26 can be driven in the same cycle as a single-bit control write to show the ordering rule.
- The default level maps put one level-5 bit and two level-6 bits next to many level-3 bits, so one status word can exercise every level of the encoder.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int MAX_SRC = 32;
    localparam int ADDR_W  = 2;
    localparam int IPL_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_DIRECT = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [IPL_W-1:0] {
        LVL_IDLE = 3'd0,
        LVL_LOW  = 3'd3,
        LVL_MID  = 3'd5,
        LVL_HIGH = 3'd6
    } ipl_e;

    typedef struct packed {
        logic status_we;
        logic mask_we;
        logic direct_we;
    } wr_ctl_t;

    function automatic wr_ctl_t decode_write(input logic en, input logic [ADDR_W-1:0] addr);
        wr_ctl_t c;
        c.status_we = en && (reg_sel_e'(addr) == SEL_STATUS);
        c.mask_we   = en && (reg_sel_e'(addr) == SEL_MASK);
        c.direct_we = en && (reg_sel_e'(addr) == SEL_DIRECT);
        return c;
    endfunction

    function automatic ipl_e encode_level(input logic [MAX_SRC-1:0] st,
                                          input logic [MAX_SRC-1:0] map5,
                                          input logic [MAX_SRC-1:0] map6);
        logic [MAX_SRC-1:0] grp3;
        grp3 = ~(map5 | map6);
        if (|(st & map6))      return LVL_HIGH;
        else if (|(st & map5)) return LVL_MID;
        else if (|(st & grp3)) return LVL_LOW;
        else                   return LVL_IDLE;
    endfunction

endpackage

// File: rtl/irq_agg_edge.sv
module irq_agg_edge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= src_i;
    end

    assign rise_o = src_i & ~prev_q;
    assign fall_o = ~src_i & prev_q;
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int N          = 32,
    parameter int DATA_W     = 32,
    parameter int DIRECT_BIT = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      rise_i,
    input  logic [N-1:0]      fall_i,
    input  wr_ctl_t           ctl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N-1:0]      status_o,
    output logic [N-1:0]      mask_o
);
    logic [N-1:0] status_q, status_d;
    logic [N-1:0] mask_q;
    logic [N-1:0] evt;

    assign evt = (rise_i & ~mask_q) | fall_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == DIRECT_BIT) begin : g_direct
            assign status_d[i] = evt[i]          ? rise_i[i]  :
                                 ctl_i.status_we ? wdata_i[i] :
                                 ctl_i.direct_we ? wdata_i[0] : status_q[i];
        end else begin : g_plain
            assign status_d[i] = evt[i]          ? rise_i[i]  :
                                 ctl_i.status_we ? wdata_i[i] : status_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            if (ctl_i.mask_we) mask_q <= wdata_i[N-1:0];
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    a_r2_unmasked_rise_sets: assert property (@(posedge clk) disable iff (rst)
        |(rise_i & ~mask_q) |=> ((status_q & $past(rise_i & ~mask_q)) == $past(rise_i & ~mask_q)));

    a_r3_masked_rise_dropped: assert property (@(posedge clk) disable iff (rst)
        (|(rise_i & mask_q) && !ctl_i.status_we && !ctl_i.direct_we)
        |=> ((status_q & $past(rise_i & mask_q)) == ($past(status_q) & $past(rise_i & mask_q))));

    a_r4_fall_clears: assert property (@(posedge clk) disable iff (rst)
        |fall_i |=> ((status_q & $past(fall_i)) == '0));

    // R5 with the R8 exception for bits that saw a source event
    a_r5_status_write: assert property (@(posedge clk) disable iff (rst)
        ctl_i.status_we |=> ((status_q & ~$past(evt)) == ($past(wdata_i[N-1:0]) & ~$past(evt))));

    a_r6_mask_write: assert property (@(posedge clk) disable iff (rst)
        ctl_i.mask_we |=> (mask_q == $past(wdata_i[N-1:0])));

    a_r7_direct_bit: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.direct_we && !evt[DIRECT_BIT]) |=> (status_q[DIRECT_BIT] == $past(wdata_i[0])));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        ((ctl_i.status_we || ctl_i.direct_we) && |evt)
        |=> ((status_q & $past(evt)) == ($past(rise_i) & $past(evt))));
endmodule

// File: rtl/irq_agg_level.sv
module irq_agg_level
    import irq_agg_pkg::*;
#(
    parameter int                 N        = 32,
    parameter logic [MAX_SRC-1:0] LVL5_MAP = 32'h0002_0000,
    parameter logic [MAX_SRC-1:0] LVL6_MAP = 32'h000C_0000
) (
    input  logic [N-1:0]     status_i,
    output logic [IPL_W-1:0] ipl_o
);
    logic [MAX_SRC-1:0] st_w;

    always_comb begin
        st_w        = '0;
        st_w[N-1:0] = status_i;
        ipl_o       = encode_level(st_w, LVL5_MAP, LVL6_MAP);
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int                 NUM_SRC    = 32,
    parameter int                 DATA_W     = 32,
    parameter int                 DIRECT_BIT = 26,
    parameter logic [MAX_SRC-1:0] LVL5_MAP   = 32'h0002_0000,
    parameter logic [MAX_SRC-1:0] LVL6_MAP   = 32'h000C_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [2:0]         ipl_o
);
    logic [NUM_SRC-1:0] rise, fall, status, mask;
    wr_ctl_t            ctl;

    assign ctl = decode_write(wr_en_i, wr_addr_i);

    irq_agg_edge #(.N(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    irq_agg_regs #(.N(NUM_SRC), .DATA_W(DATA_W), .DIRECT_BIT(DIRECT_BIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise),
        .fall_i   (fall),
        .ctl_i    (ctl),
        .wdata_i  (wr_data_i),
        .status_o (status),
        .mask_o   (mask)
    );

    irq_agg_level #(.N(NUM_SRC), .LVL5_MAP(LVL5_MAP), .LVL6_MAP(LVL6_MAP)) u_level (
        .status_i (status),
        .ipl_o    (ipl_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (reg_sel_e'(rd_addr_i))
            SEL_STATUS: rd_data_o[NUM_SRC-1:0] = status;
            SEL_MASK:   rd_data_o[NUM_SRC-1:0] = mask;
            default:    rd_data_o = '0;
        endcase
    end

    a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> (ipl_o == 3'd0));

    a_r9_top_level: assert property (@(posedge clk) disable iff (rst)
        (|(status & LVL6_MAP[NUM_SRC-1:0])) |-> (ipl_o == 3'd6));

    a_r10_unused_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == 2'd3 && rise == '0 && fall == '0)
        |=> (status == $past(status) && mask == $past(mask)));
endmodule

// File: tb/irq_agg_ctrl_bench.sv
module irq_agg_ctrl_bench;
    localparam int NS = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic          we = 1'b0;
    logic [1:0]    waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [1:0]    raddr = '0;
    logic [DW-1:0] rdata;
    logic [2:0]    ipl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string       tag;
        logic [1:0]  addr;
        bit          is_ipl;
        logic [31:0] exp;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    irq_agg_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .DIRECT_BIT(26),
                   .LVL5_MAP(32'h0002_0000), .LVL6_MAP(32'h000C_0000)) u_irq_agg_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .wr_en_i   (we),
        .wr_addr_i (waddr),
        .wr_data_i (wdata),
        .rd_addr_i (raddr),
        .rd_data_o (rdata),
        .ipl_o     (ipl)
    );

    function automatic void exp_reg(string tag, logic [1:0] a, logic [31:0] v);
        item_t it;
        it.tag = tag; it.addr = a; it.is_ipl = 1'b0; it.exp = v;
        q.push_back(it);
    endfunction

    function automatic void exp_ipl(string tag, logic [2:0] v);
        item_t it;
        it.tag = tag; it.addr = 2'd0; it.is_ipl = 1'b1; it.exp = {29'd0, v};
        q.push_back(it);
    endfunction

    // monitor: pops expectations after each commit edge and compares
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (q.size() != 0);
            #1;
            it = q.pop_front();
            raddr = it.addr;
            #1;
            got = it.is_ipl ? {29'd0, ipl} : rdata;
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    // one commit edge with the given stimulus
    task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                        input logic [NS-1:0] s);
        wait (q.size() == 0);
        @(negedge clk);
        we = w; waddr = a; wdata = d; src = s;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    initial begin
        logic [NS-1:0] s;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        step(0, 0, 0, '0);
        exp_reg("R1 status after reset", 0, 32'h0);
        exp_reg("R1 mask after reset", 1, 32'h0);
        exp_ipl("R1 level after reset", 3'd0);

        s = '0; s[3] = 1;
        step(0, 0, 0, s);
        exp_reg("R2 bit3 set", 0, 32'h0000_0008);
        exp_ipl("R9 level3 only", 3'd3);

        s[17] = 1;
        step(0, 0, 0, s);
        exp_reg("R2 bit17 set", 0, 32'h0002_0008);
        exp_ipl("R9 level5 over 3", 3'd5);

        s[18] = 1;
        step(0, 0, 0, s);
        exp_reg("R2 bit18 set", 0, 32'h0006_0008);
        exp_ipl("R9 level6 over 5", 3'd6);

        s[18] = 0;
        step(0, 0, 0, s);
        exp_reg("R4 bit18 cleared", 0, 32'h0002_0008);
        exp_ipl("R9 back to 5", 3'd5);

        s = '0;
        step(0, 0, 0, s);
        exp_reg("R4 all cleared", 0, 32'h0);
        exp_ipl("R9 idle", 3'd0);

        step(1, 1, 32'h0000_00F0, s);
        exp_reg("R6 mask written", 1, 32'h0000_00F0);
        exp_reg("R6 status untouched", 0, 32'h0);

        s[4] = 1; s[8] = 1;
        step(0, 0, 0, s);
        exp_reg("R3 masked bit4 dropped, R2 bit8 set", 0, 32'h0000_0100);

        step(1, 0, 32'h0000_0110, s);
        exp_reg("R5 status written", 0, 32'h0000_0110);

        s[4] = 0;
        step(0, 0, 0, s);
        exp_reg("R4 masked fall clears", 0, 32'h0000_0100);

        step(1, 0, 32'hA5A5_0000, s);
        exp_reg("R5 whole word replaced", 0, 32'hA5A5_0000);
        exp_ipl("R9 level6 from write", 3'd6);

        step(1, 2, 32'h0000_0000, s);
        exp_reg("R7 direct clear bit26", 0, 32'hA1A5_0000);

        step(1, 2, 32'hFFFF_FFF1, s);
        exp_reg("R7 direct set bit26 only", 0, 32'hA5A5_0000);

        step(1, 0, 32'h0, s);
        exp_reg("R5 status cleared", 0, 32'h0);
        exp_ipl("R9 idle after clear", 3'd0);

        s[8] = 0;
        step(1, 0, 32'hFFFF_FFFF, s);
        exp_reg("R8 fall beats write", 0, 32'hFFFF_FEFF);

        s[10] = 1;
        step(1, 0, 32'h0, s);
        exp_reg("R8 rise beats write", 0, 32'h0000_0400);

        s[26] = 1;
        step(1, 2, 32'h0, s);
        exp_reg("R8 rise beats direct write", 0, 32'h0400_0400);

        step(1, 3, 32'hFFFF_FFFF, s);
        exp_reg("R10 status kept", 0, 32'h0400_0400);
        exp_reg("R10 mask kept", 1, 32'h0000_00F0);
        exp_reg("R10 unused reads zero", 3, 32'h0);
        exp_reg("R10 repeat read no side effect", 0, 32'h0400_0400);
        exp_ipl("R9 level3 mix", 3'd3);

        wait (q.size() == 0);
        #5;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule